// File: doc/BRIEF.md
# Keyed-restart watchdog timer

This block is a memory-mapped watchdog timer with 32-bit word registers. Software sets a reload value and turns the timer on through a control register. From then on a down-counter falls by one on each tick of the selected time base. Two time bases are offered: a fast peripheral tick, nominally 24 MHz, and a 1 MHz tick. To keep the timer from running out, software writes a 16-bit key to the restart register, and the counter then starts again from the reload value. Any write without the exact key has no effect.

When the counter runs out, the block stops counting. It sends a one-cycle timeout event and, at the same time, a one-cycle pulse on each action output that the control register enables: system reset request, interrupt request and external reset trigger. If the memory-controller reset-hold input is high when the counter runs out, the block sends none of these pulses. It clears the whole control register instead, which turns the timer off. A control write is taken only when it changes the enable bit. Writes that leave the enable state as it is are dropped.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the counter and the reload register both read 0x03EF1480, the control register reads 0, the reset-width register reads 0x000000FF, and all four event outputs are low.
- R2: The register map is 0x00 live counter (read-only), 0x04 reload value (read/write), 0x0C control (read/write), 0x18 reset width (keeps bits [7:0], other bits read 0) and 0x1C reset mask (read/write, 32 bits). A read strobe in one cycle puts the read data on `bus_rdata` in the next cycle.
- R3: A write to 0x08 whose bits [15:0] equal 0x4755 copies the reload value into the counter, whatever the upper 16 bits hold. A write to 0x08 with any other value in bits [15:0] leaves the counter unchanged. A read of 0x08 returns 0.
- R4: A write to 0x0C is stored only when its bit 0 differs from the stored enable bit. Any other control write leaves the control register unchanged.
- R5: A control write that sets the enable bit loads the counter from the reload value. While the timer is on, the counter falls by one on each tick of the selected time base: `tick_1m` when control bit 4 is 1, `tick_fast` when it is 0. A tick of the time base that is not selected has no effect.
- R6: A selected tick that arrives while the counter holds 1 (or 0) is the expiry. The counter goes to 0 and `timeout_evt` is high for exactly one cycle, the cycle after that tick. The counter then stays put until a key restart or a new enable.
- R7: At expiry, `sys_rst_req`, `irq_req` and `ext_trig` pulse together with `timeout_evt` when control bits 1, 2 and 3 respectively are set. Otherwise they stay low.
- R8: If `mem_hold` is high when expiry occurs, all four event outputs stay low and the control register is cleared to 0.
- R9: When a key restart and a selected tick arrive in the same cycle, the counter loads the reload value.
- R10: A control write that clears the enable bit freezes the counter at its present value. Ticks then have no effect.
- R11: Reads of 0x10, 0x14 and unmapped offsets return 0. Writes to 0x00 and to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| tick_fast | input | 1 | Peripheral time-base tick |
| tick_1m | input | 1 | 1 MHz time-base tick |
| mem_hold | input | 1 | Memory-controller reset hold |
| timeout_evt | output | 1 | One-cycle expiry pulse |
| sys_rst_req | output | 1 | System reset request pulse |
| irq_req | output | 1 | Interrupt request pulse |
| ext_trig | output | 1 | External reset trigger pulse |

## Verification
The countdown is swept over reload values 1 to 8. The time base alternates from one value to the next, and the action bits follow the three low bits of the value, so every action combination is met. Reading the counter after each tick confirms the step size. Ticks of the time base that is not selected are also sent, which shows the time-base selection works. The first pulse must appear on the final tick and not before it, and checking this at every length catches off-by-one errors in the expiry point. Further sequences cover:
- wrong keys against right keys that carry junk in the upper half,
- a key restart in the same cycle as a tick,
- control writes that do not change the enable bit,
- expiry with the hold input asserted,
- reads of reserved and unmapped offsets.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFF_COUNT  = 8'h00;
  localparam logic [7:0] OFF_RELOAD = 8'h04;
  localparam logic [7:0] OFF_KICK   = 8'h08;
  localparam logic [7:0] OFF_CTRL   = 8'h0C;
  localparam logic [7:0] OFF_WIDTH  = 8'h18;
  localparam logic [7:0] OFF_MASK   = 8'h1C;

  localparam int CB_EN    = 0;
  localparam int CB_SYS   = 1;
  localparam int CB_IRQ   = 2;
  localparam int CB_EXT   = 3;
  localparam int CB_SLOW  = 4;
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int               ADDR_W      = 8,
  parameter logic [DATA_W-1:0] RELOAD_INIT = 32'h03EF1480,
  parameter int               WIDTH_BITS  = 8,
  parameter logic [WIDTH_BITS-1:0] WIDTH_INIT = '1,
  parameter logic [15:0]      KEY         = 16'h4755
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  input  logic [DATA_W-1:0] cnt,
  input  logic              hold_clear,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] ctrl,
  output logic              en_rise,
  output logic              en_fall,
  output logic              restart
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_KICK   = ADDR_W'(OFF_KICK);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_WIDTH  = ADDR_W'(OFF_WIDTH);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);

  logic [WIDTH_BITS-1:0] width_q;
  logic [DATA_W-1:0]     mask_q;
  logic [DATA_W-1:0]     rd_mux;

  assign en_rise = we && (addr == A_CTRL) &&  wdata[CB_EN] && !ctrl[CB_EN];
  assign en_fall = we && (addr == A_CTRL) && !wdata[CB_EN] &&  ctrl[CB_EN];
  assign restart = we && (addr == A_KICK) && (wdata[15:0] == KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload  <= RELOAD_INIT;
      ctrl    <= '0;
      width_q <= WIDTH_INIT;
      mask_q  <= '0;
    end else begin
      if (we && addr == A_RELOAD) reload  <= wdata;
      if (we && addr == A_WIDTH)  width_q <= wdata[WIDTH_BITS-1:0];
      if (we && addr == A_MASK)   mask_q  <= wdata;
      if (hold_clear)              ctrl <= '0;
      else if (en_rise || en_fall) ctrl <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      A_COUNT:  rd_mux = cnt;
      A_RELOAD: rd_mux = reload;
      A_CTRL:   rd_mux = ctrl;
      A_WIDTH:  rd_mux = DATA_W'(width_q);
      A_MASK:   rd_mux = mask_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_mux;
  end
endmodule

// File: rtl/kwd_count.sv
module kwd_count
  import kwd_pkg::*;
#(
  parameter logic [DATA_W-1:0] CNT_INIT = 32'h03EF1480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_fast,
  input  logic              tick_1m,
  input  logic              use_slow,
  input  logic              ctrl_en,
  input  logic              en_rise,
  input  logic              en_fall,
  input  logic              restart,
  input  logic              mem_hold,
  input  logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] cnt,
  output logic              hold_clear,
  output logic              fire
);
  logic run_q;
  logic tick_sel;
  logic expire_now;

  assign tick_sel   = use_slow ? tick_1m : tick_fast;
  assign expire_now = run_q && tick_sel && (cnt <= DATA_W'(1)) &&
                      !restart && !en_rise && !en_fall;
  assign hold_clear = expire_now &&  mem_hold;
  assign fire       = expire_now && !mem_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= CNT_INIT;
      run_q <= 1'b0;
    end else if (en_fall) begin
      run_q <= 1'b0;
    end else if (en_rise || restart) begin
      cnt   <= reload;
      run_q <= en_rise || ctrl_en;
    end else if (expire_now) begin
      cnt   <= '0;
      run_q <= 1'b0;
    end else if (run_q && tick_sel) begin
      cnt   <= cnt - DATA_W'(1);
    end
  end
endmodule

// File: rtl/kwd_actions.sv
module kwd_actions
  import kwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [DATA_W-1:0] ctrl,
  output logic              timeout_evt,
  output logic              sys_rst_req,
  output logic              irq_req,
  output logic              ext_trig
);
  always_ff @(posedge clk) begin
    if (rst) begin
      timeout_evt <= 1'b0;
      sys_rst_req <= 1'b0;
      irq_req     <= 1'b0;
      ext_trig    <= 1'b0;
    end else begin
      timeout_evt <= fire;
      sys_rst_req <= fire && ctrl[CB_SYS];
      irq_req     <= fire && ctrl[CB_IRQ];
      ext_trig    <= fire && ctrl[CB_EXT];
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter logic [DATA_W-1:0] CNT_INIT   = 32'h03EF1480,
  parameter int               WIDTH_BITS = 8,
  parameter logic [15:0]      KEY        = 16'h4755
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_1m,
  input  logic              mem_hold,
  output logic              timeout_evt,
  output logic              sys_rst_req,
  output logic              irq_req,
  output logic              ext_trig
);
  logic [DATA_W-1:0] cnt_w;
  logic [DATA_W-1:0] reload_w;
  logic [DATA_W-1:0] ctrl_w;
  logic en_rise_w, en_fall_w, restart_w, hold_clear_w, fire_w;

  kwd_regs #(
    .ADDR_W(ADDR_W), .RELOAD_INIT(CNT_INIT), .WIDTH_BITS(WIDTH_BITS),
    .WIDTH_INIT('1), .KEY(KEY)
  ) i_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .cnt(cnt_w), .hold_clear(hold_clear_w),
    .rdata(bus_rdata), .reload(reload_w), .ctrl(ctrl_w),
    .en_rise(en_rise_w), .en_fall(en_fall_w), .restart(restart_w)
  );

  kwd_count #(.CNT_INIT(CNT_INIT)) i_count (
    .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_1m(tick_1m),
    .use_slow(ctrl_w[CB_SLOW]), .ctrl_en(ctrl_w[CB_EN]),
    .en_rise(en_rise_w), .en_fall(en_fall_w), .restart(restart_w),
    .mem_hold(mem_hold), .reload(reload_w), .cnt(cnt_w),
    .hold_clear(hold_clear_w), .fire(fire_w)
  );

  kwd_actions i_actions (
    .clk(clk), .rst(rst), .fire(fire_w), .ctrl(ctrl_w),
    .timeout_evt(timeout_evt), .sys_rst_req(sys_rst_req),
    .irq_req(irq_req), .ext_trig(ext_trig)
  );
endmodule

// File: rtl/kwd_checks.sv
module kwd_checks (
  input logic        clk,
  input logic        rst,
  input logic        timeout_evt,
  input logic        sys_rst_req,
  input logic        irq_req,
  input logic        ext_trig,
  input logic        mem_hold,
  input logic [31:0] cnt,
  input logic [31:0] reload,
  input logic [31:0] ctrl,
  input logic        restart,
  input logic        en_rise
);
  // R6: the timeout pulse lasts one cycle
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |=> !timeout_evt);
  // R6: counter sits at zero while the pulse is out
  a_r6_count_zero: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |-> (cnt == 32'd0));
  // R7: actions only accompany a timeout
  a_r7_sys_with_evt: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> timeout_evt);
  a_r7_irq_with_evt: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> timeout_evt);
  a_r7_ext_with_evt: assert property (@(posedge clk) disable iff (rst)
    ext_trig |-> timeout_evt);
  // R8: no event when the hold input was high at expiry
  a_r8_hold_silent: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |-> !$past(mem_hold));
  // R3: a key restart loads the reload value
  a_r3_key_loads: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == $past(reload)));
  // R10: a disabled timer does not move without a load
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[0] && !restart && !en_rise) |=> $stable(cnt));
endmodule

bind keyed_wdog kwd_checks i_kwd_checks (
  .clk(clk), .rst(rst), .timeout_evt(timeout_evt), .sys_rst_req(sys_rst_req),
  .irq_req(irq_req), .ext_trig(ext_trig), .mem_hold(mem_hold),
  .cnt(cnt_w), .reload(reload_w), .ctrl(ctrl_w),
  .restart(restart_w), .en_rise(en_rise_w)
);

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        tick_fast = 1'b0;
  logic        tick_1m = 1'b0;
  logic        mem_hold = 1'b0;
  logic        timeout_evt, sys_rst_req, irq_req, ext_trig;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  keyed_wdog i_keyed_wdog (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .tick_fast(tick_fast), .tick_1m(tick_1m), .mem_hold(mem_hold),
    .timeout_evt(timeout_evt), .sys_rst_req(sys_rst_req),
    .irq_req(irq_req), .ext_trig(ext_trig)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input bit slow);
    if (slow) tick_1m = 1'b1; else tick_fast = 1'b1;
    @(negedge clk);
    tick_1m = 1'b0; tick_fast = 1'b0;
  endtask

  function automatic logic [3:0] evts();
    return {ext_trig, irq_req, sys_rst_req, timeout_evt};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 events", {28'd0, evts()}, 32'd0);
    rd(8'h00, v); chk("R1 counter", v, 32'h03EF1480);
    rd(8'h04, v); chk("R1 reload", v, 32'h03EF1480);
    rd(8'h0C, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h18, v); chk("R1 width", v, 32'h000000FF);

    // R2 register access
    wr(8'h1C, 32'hDEADBEEF); rd(8'h1C, v); chk("R2 mask", v, 32'hDEADBEEF);
    wr(8'h18, 32'h00012345); rd(8'h18, v); chk("R2 width low bits", v, 32'h45);
    wr(8'h04, 32'h0000_0077); rd(8'h04, v); chk("R2 reload", v, 32'h77);

    // R11 reserved / unmapped
    rd(8'h10, v); chk("R11 read 0x10", v, 0);
    rd(8'h14, v); chk("R11 read 0x14", v, 0);
    rd(8'h40, v); chk("R11 read unmapped", v, 0);
    rd(8'h08, v); chk("R3 read kick", v, 0);
    wr(8'h00, 32'h12345678); rd(8'h00, v); chk("R11 write counter ignored", v, 32'h03EF1480);
    wr(8'h40, 32'hFFFFFFFF);
    rd(8'h04, v); chk("R11 unmapped write reload", v, 32'h77);
    rd(8'h1C, v); chk("R11 unmapped write mask", v, 32'hDEADBEEF);

    // R5/R6/R7 countdown sweep
    for (int n = 1; n <= 8; n++) begin
      bit slow;
      logic [3:0] exp_ev;
      slow = n[0];
      c = 32'h1 | (32'(n & 7) << 1) | (32'(slow) << 4);
      exp_ev = {n[2], n[1], n[0], 1'b1};
      wr(8'h04, 32'(n));
      wr(8'h0C, c);
      rd(8'h00, v); chk($sformatf("R5 load n=%0d", n), v, 32'(n));
      tick(!slow);
      rd(8'h00, v); chk($sformatf("R5 other tick n=%0d", n), v, 32'(n));
      for (int k = 1; k < n; k++) begin
        tick(slow);
        chk($sformatf("R6 early n=%0d k=%0d", n, k), {28'd0, evts()}, 32'd0);
        rd(8'h00, v); chk($sformatf("R5 step n=%0d k=%0d", n, k), v, 32'(n - k));
      end
      tick(slow);
      chk($sformatf("R7 expiry events n=%0d", n), {28'd0, evts()}, {28'd0, exp_ev});
      @(negedge clk);
      chk($sformatf("R6 pulse ends n=%0d", n), {28'd0, evts()}, 32'd0);
      tick(slow);
      chk($sformatf("R6 stopped no event n=%0d", n), {28'd0, evts()}, 32'd0);
      rd(8'h00, v); chk($sformatf("R6 stopped n=%0d", n), v, 0);
      rd(8'h0C, v); chk($sformatf("R6 ctrl kept n=%0d", n), v, c);
      wr(8'h0C, 32'h0);
    end

    // R3 key handling, R4 discard, R9 priority
    wr(8'h04, 32'd5);
    wr(8'h0C, 32'h3);
    tick(1'b0); tick(1'b0);
    rd(8'h00, v); chk("R5 two ticks", v, 3);
    wr(8'h08, 32'h0000_4756);
    rd(8'h00, v); chk("R3 wrong key ignored", v, 3);
    wr(8'h08, 32'hABCD_4755);
    rd(8'h00, v); chk("R3 key with junk upper", v, 5);
    tick(1'b0); tick(1'b0);
    bus_addr = 8'h08; bus_wdata = 32'h4755; bus_we = 1'b1; tick_fast = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_fast = 1'b0;
    rd(8'h00, v); chk("R9 restart beats tick", v, 5);
    wr(8'h0C, 32'h1F);
    rd(8'h0C, v); chk("R4 same-enable write discarded", v, 32'h3);
    tick(1'b1);
    rd(8'h00, v); chk("R4 time base unchanged", v, 5);
    tick(1'b0);
    rd(8'h00, v); chk("R5 fast tick counts", v, 4);

    // R10 disable freezes
    wr(8'h0C, 32'h1E);
    rd(8'h0C, v); chk("R4 disabling write stored", v, 32'h1E);
    tick(1'b0); tick(1'b1);
    rd(8'h00, v); chk("R10 frozen", v, 4);
    wr(8'h0C, 32'h1E);
    rd(8'h0C, v); chk("R4 disabled same write", v, 32'h1E);
    wr(8'h08, 32'h4755);
    rd(8'h00, v); chk("R3 key while disabled loads", v, 5);
    tick(1'b0);
    rd(8'h00, v); chk("R10 no count after key while off", v, 5);

    // R8 hold at expiry
    wr(8'h04, 32'd2);
    wr(8'h0C, 32'h0F);
    mem_hold = 1'b1;
    tick(1'b0);
    tick(1'b0);
    chk("R8 no events", {28'd0, evts()}, 32'd0);
    @(negedge clk);
    chk("R8 still none", {28'd0, evts()}, 32'd0);
    rd(8'h0C, v); chk("R8 ctrl cleared", v, 0);
    rd(8'h00, v); chk("R8 counter zero", v, 0);
    mem_hold = 1'b0;

    // R1 reset again mid-run
    wr(8'h0C, 32'h1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    rd(8'h0C, v); chk("R1 ctrl after reset", v, 0);
    rd(8'h18, v); chk("R1 width after reset", v, 32'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule